// File: doc/BRIEF.md
# Receive FIFO with Programmable Level Flags

This block buffers 32-bit words that arrive from a parallel input link until a DMA engine reads them out. Its storage is a circular buffer of `DEPTH` words, where `DEPTH` is a power of two from 2 to 2^19. A small register port lets software do five things: set the almost-empty and almost-full thresholds, watch four level flags, read the live word count and the fixed capacity, and control the block. The level flags are active-high "not" indications: not empty, not almost empty, not almost full and not full. Overrun and underrun are recorded as sticky error bits, and software clears them by writing one to them.

Neither side of the data path can be stalled. The link presents a word with `link_valid` in any cycle and has no ready signal, so the FIFO cannot push back on it. A word that arrives while the FIFO is full is lost and is reported as an overrun. The DMA side pulls a word by raising `dma_rd` for one cycle. In that same cycle `dma_data` shows the oldest stored word, and the word is removed at the clock edge. A pull from an empty FIFO returns zero and is reported as an underrun. The DMA engine is expected to pace its reads from the flags. Register reads are combinational from `reg_addr`. A register write takes effect at the clock edge on which `reg_wr` is high.

The control register has three effects. A whole-block reset returns every register and the storage to the reset state. It then holds the FIFO inactive for `SETTLE_CYC` cycles, which by default is 500 cycles, about 10 µs at 50 MHz. A FIFO flush empties the storage and leaves everything else unchanged. The receive enable gates link writes.

Top module: `rxfifo_prog`

## Requirements
- R1: After reset, the register port reads as follows: control word 0, thresholds 0, count 0, size `DEPTH`, and status 0x0000C000 (not-full and not-almost-full set, everything else clear).
- R2: While receive is enabled and the FIFO is active, each `link_valid` word is stored unless the FIFO is full with no pop in the same cycle. `dma_rd` on a non-empty FIFO returns the oldest word on `dma_data` in that same cycle and removes it at the edge, so words leave in arrival order.
- R3: While receive enable (control word address 0, bit 5) is 0, link words are ignored: the count does not grow and no overrun is recorded.
- R4: A link word that arrives while the FIFO is full and no pop happens in that cycle is dropped. The count stays at `DEPTH` and status bit 23 (overrun) becomes 1.
- R5: `dma_rd` on an empty, active FIFO gives `dma_data` = 0, leaves the count at 0, and sets status bit 22 (underrun).
- R6: Status bits 22 and 23 stay set until software writes to status (address 1) with a 1 in that bit position. Writing 0 leaves the bit unchanged. A new error event in the same cycle as a clearing write leaves the bit set.
- R7: The threshold register (address 2) holds the almost-empty threshold AE in bits 15:0 and the almost-full threshold AF in bits 23:16. Status bit 13 is 1 exactly when count > AE. Status bit 14 is 1 exactly when count + AF < `DEPTH`.
- R8: Status bit 12 is 1 exactly when count > 0, and bit 15 is 1 exactly when count < `DEPTH`. The count never exceeds `DEPTH`.
- R9: The count register (address 4) reports the live word count in bits 19:0. The size register (address 3) reports `DEPTH` in bits 19:0. Unmapped addresses read 0.
- R10: Writing control with bit 2 set flushes the FIFO: the count becomes 0 at that edge and no push, pop or error event happens in that cycle. Thresholds and error bits are kept. Bit 2 reads back as 0, and receive enable takes the value of bit 5 from the same write.
- R11: Writing control with bit 0 set clears receive enable, both thresholds, both error bits and the storage. For the next `SETTLE_CYC` cycles, link words and DMA reads are ignored: the count stays 0, `dma_data` is 0, and no error is recorded. Register writes are still accepted during that window.
- R12: Control reads back receive enable in bit 5, and every other bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_valid | input | 1 | Link word present this cycle |
| link_data | input | 32 | Link word |
| dma_rd | input | 1 | DMA pulls one word this cycle |
| dma_data | output | 32 | Oldest word while pulling, else 0 |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The bench builds the block with `DEPTH` = 16 and `SETTLE_CYC` = 12. With a depth that small, random link and DMA traffic reaches full and empty many times, so overrun, underrun, simultaneous push and pop at full, and both threshold boundaries all occur often. The short settling window lets whole-block resets fall in the middle of random traffic without the run becoming long. Threshold values up to 19 are larger than the depth, which also covers the cases where a flag is pinned to one state for every count.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_THR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SIZE = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

  localparam int unsigned C_BLKRST = 0;
  localparam int unsigned C_FLUSH  = 2;
  localparam int unsigned C_RXEN   = 5;

  localparam int unsigned S_NE  = 12;
  localparam int unsigned S_NAE = 13;
  localparam int unsigned S_NAF = 14;
  localparam int unsigned S_NF  = 15;
  localparam int unsigned S_UNR = 22;
  localparam int unsigned S_OVR = 23;

  localparam int unsigned FIELD_W = 20;

  typedef struct packed {
    logic nf;
    logic naf;
    logic nae;
    logic ne;
  } lvl_flags_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rdata = mem[rd_ptr];
  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/rxf_levels.sv
module rxf_levels
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7,
  localparam int unsigned SW   = ((CW > 16) ? CW : 16) + 2
) (
  input  logic [CW-1:0] count,
  input  logic [15:0]   ae_thr,
  input  logic [7:0]    af_thr,
  output lvl_flags_t    flags
);
  logic [SW-1:0] cnt_x, ae_x, af_x;

  always_comb begin
    cnt_x     = SW'(count);
    ae_x      = SW'(ae_thr);
    af_x      = SW'(af_thr);
    flags.ne  = (cnt_x != '0);
    flags.nae = (cnt_x > ae_x);
    flags.naf = ((cnt_x + af_x) < SW'(DEPTH));
    flags.nf  = (cnt_x < SW'(DEPTH));
  end
endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 500,
  localparam int unsigned SCW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  input  logic              link_valid,
  input  logic              dma_rd,
  input  logic              full,
  input  logic              empty,
  output logic              push,
  output logic              pop,
  output logic              flush,
  output logic              active,
  output logic              rx_en,
  output logic [15:0]       ae_thr,
  output logic [7:0]        af_thr,
  output logic              ovr_err,
  output logic              unr_err
);
  logic [SCW-1:0] settle_q;
  logic ctrl_wr, blk_rst, act, ovr_ev, unr_ev, stat_wr;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:24], reg_wdata[21:6], reg_wdata[4:3], reg_wdata[1]};

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);
  assign stat_wr = reg_wr && (reg_addr == A_STAT);
  assign blk_rst = ctrl_wr && reg_wdata[C_BLKRST];
  assign flush   = ctrl_wr && (reg_wdata[C_BLKRST] || reg_wdata[C_FLUSH]);
  assign active  = (settle_q == '0);
  assign act     = active && !flush;

  assign pop    = act && dma_rd && !empty;
  assign push   = act && link_valid && rx_en && (!full || pop);
  assign ovr_ev = act && link_valid && rx_en && full && !pop;
  assign unr_ev = act && dma_rd && empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
      rx_en    <= 1'b0;
      ae_thr   <= '0;
      af_thr   <= '0;
      ovr_err  <= 1'b0;
      unr_err  <= 1'b0;
    end else if (blk_rst) begin
      settle_q <= SCW'(SETTLE_CYC);
      rx_en    <= 1'b0;
      ae_thr   <= '0;
      af_thr   <= '0;
      ovr_err  <= 1'b0;
      unr_err  <= 1'b0;
    end else begin
      if (settle_q != '0) settle_q <= settle_q - 1'b1;
      if (ctrl_wr) rx_en <= reg_wdata[C_RXEN];
      if (reg_wr && (reg_addr == A_THR)) begin
        ae_thr <= reg_wdata[15:0];
        af_thr <= reg_wdata[23:16];
      end
      ovr_err <= (ovr_err && !(stat_wr && reg_wdata[S_OVR])) || ovr_ev;
      unr_err <= (unr_err && !(stat_wr && reg_wdata[S_UNR])) || unr_ev;
    end
  end
endmodule

// File: rtl/rxfifo_prog.sv
module rxfifo_prog
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH      = 64,
  parameter int unsigned SETTLE_CYC = 500,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_valid,
  input  logic [31:0]       link_data,
  input  logic              dma_rd,
  output logic [31:0]       dma_data,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);
  localparam logic [FIELD_W-1:0] SIZE_F = FIELD_W'(DEPTH);

  logic          push, pop, flush, active, rx_en, ovr_err, unr_err;
  logic          full, empty;
  logic [CW-1:0] count;
  logic [31:0]   head;
  logic [15:0]   ae_thr;
  logic [7:0]    af_thr;
  lvl_flags_t    flags;

  rxf_ctrl #(.SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .link_valid(link_valid), .dma_rd(dma_rd),
    .full(full), .empty(empty), .push(push), .pop(pop), .flush(flush),
    .active(active), .rx_en(rx_en), .ae_thr(ae_thr), .af_thr(af_thr),
    .ovr_err(ovr_err), .unr_err(unr_err)
  );

  rxf_store #(.DEPTH(DEPTH), .W(32)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .pop(pop),
    .wdata(link_data), .rdata(head), .count(count), .full(full), .empty(empty)
  );

  rxf_levels #(.DEPTH(DEPTH), .CW(CW)) u_levels (
    .count(count), .ae_thr(ae_thr), .af_thr(af_thr), .flags(flags)
  );

  assign dma_data = pop ? head : '0;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: reg_rdata[C_RXEN] = rx_en;
      A_STAT: begin
        reg_rdata[S_NE]  = flags.ne;
        reg_rdata[S_NAE] = flags.nae;
        reg_rdata[S_NAF] = flags.naf;
        reg_rdata[S_NF]  = flags.nf;
        reg_rdata[S_UNR] = unr_err;
        reg_rdata[S_OVR] = ovr_err;
      end
      A_THR:   reg_rdata[23:0] = {af_thr, ae_thr};
      A_SIZE:  reg_rdata[FIELD_W-1:0] = SIZE_F;
      A_CNT:   reg_rdata[FIELD_W-1:0] = FIELD_W'(count);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] count,
  input logic          full,
  input logic          empty,
  input logic          flush,
  input logic          active,
  input logic          link_valid,
  input logic          rx_en,
  input logic          dma_rd,
  input logic [31:0]   dma_data,
  input logic          ovr_err,
  input logic          unr_err
);
  assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_overrun_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !flush && rx_en && link_valid && full && !dma_rd)
      |=> (ovr_err && count == CW'(DEPTH)));

  assert_underrun_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !flush && dma_rd && empty) |-> (dma_data == '0));

  assert_underrun_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !flush && dma_rd && empty) |=> unr_err);

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));

  assert_settle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> $stable(count));

  assert_rx_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (count <= $past(count)));
endmodule

bind rxfifo_prog rxf_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .full(full), .empty(empty),
  .flush(flush), .active(active), .link_valid(link_valid), .rx_en(rx_en),
  .dma_rd(dma_rd), .dma_data(dma_data), .ovr_err(ovr_err), .unr_err(unr_err)
);

// File: tb/tb_rxfifo_prog.sv
module tb_rxfifo_prog;
  localparam int DEPTH  = 16;
  localparam int SETTLE = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        link_valid = 1'b0;
  logic [31:0] link_data = '0;
  logic        dma_rd = 1'b0;
  logic [31:0] dma_data;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  rxfifo_prog #(.DEPTH(DEPTH), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .link_valid(link_valid), .link_data(link_data),
    .dma_rd(dma_rd), .dma_data(dma_data), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0] q[$];
  bit          m_rxen, m_ovr, m_unr;
  logic [15:0] m_ae;
  logic [7:0]  m_af;
  int          m_settle;
  logic [31:0] last_rd;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reg(input logic [2:0] a);
    logic [31:0] r;
    int n;
    n = q.size();
    r = '0;
    case (a)
      3'd0: r[5] = m_rxen;
      3'd1: begin
        r[12] = (n > 0);
        r[13] = (n > int'(m_ae));
        r[14] = ((n + int'(m_af)) < DEPTH);
        r[15] = (n < DEPTH);
        r[22] = m_unr;
        r[23] = m_ovr;
      end
      3'd2: r[23:0] = {m_af, m_ae};
      3'd3: r = 32'(DEPTH);
      3'd4: r = 32'(n);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [2:0] a);
    case (a)
      3'd0: return "R12";
      3'd1: return "R7";
      3'd2: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic model_step(input bit lv, input logic [31:0] ld, input bit rd,
                            input logic [2:0] a, input bit wr, input logic [31:0] wd);
    int n;
    bit blk, fl, act, pp, ps, ov, un;
    n   = q.size();
    blk = wr && a == 3'd0 && wd[0];
    fl  = wr && a == 3'd0 && (wd[0] || wd[2]);
    act = (m_settle == 0) && !fl;
    pp  = act && rd && n > 0;
    ps  = act && lv && m_rxen && (n < DEPTH || pp);
    ov  = act && lv && m_rxen && n == DEPTH && !pp;
    un  = act && rd && n == 0;
    if (blk) begin
      q.delete();
      m_rxen = 0; m_ae = '0; m_af = '0; m_ovr = 0; m_unr = 0;
      m_settle = SETTLE;
    end else begin
      if (m_settle > 0) m_settle--;
      if (fl) q.delete();
      if (pp) void'(q.pop_front());
      if (ps) q.push_back(ld);
      if (wr && a == 3'd0) m_rxen = wd[5];
      if (wr && a == 3'd2) begin m_ae = wd[15:0]; m_af = wd[23:16]; end
      if (wr && a == 3'd1) begin
        if (wd[23]) m_ovr = 0;
        if (wd[22]) m_unr = 0;
      end
      m_ovr = m_ovr || ov;
      m_unr = m_unr || un;
    end
  endtask

  task automatic cyc(input string tag, input bit lv, input logic [31:0] ld, input bit rd,
                     input logic [2:0] a, input bit wr, input logic [31:0] wd);
    logic [31:0] exp_d;
    bit fl;
    @(negedge clk);
    link_valid = lv; link_data = ld; dma_rd = rd;
    reg_addr = a; reg_wr = wr; reg_wdata = wd;
    #2;
    check(tag, reg_rdata, exp_reg(a));
    last_rd = reg_rdata;
    fl = wr && a == 3'd0 && (wd[0] || wd[2]);
    exp_d = (m_settle == 0 && !fl && rd && q.size() > 0) ? q[0] : 32'h0;
    check((q.size() == 0) ? "R5" : "R2", dma_data, exp_d);
    @(posedge clk);
    model_step(lv, ld, rd, a, wr, wd);
  endtask

  task automatic rd_reg(input string tag, input logic [2:0] a);
    cyc(tag, 0, '0, 0, a, 0, '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] wd;
    logic [2:0]  a;
    bit lv, rd, wr;
    void'($urandom(32'h5eed_0017));
    m_rxen = 0; m_ovr = 0; m_unr = 0; m_ae = '0; m_af = '0; m_settle = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    rd_reg("R1", 3'd1); check("R1", last_rd, 32'h0000_C000);
    rd_reg("R1", 3'd3); check("R1", last_rd, 32'd16);
    rd_reg("R1", 3'd4); check("R1", last_rd, 32'd0);
    rd_reg("R1", 3'd0); check("R1", last_rd, 32'd0);
    rd_reg("R9", 3'd6); check("R9", last_rd, 32'd0);

    // R3: link ignored while receive disabled
    for (int i = 0; i < 3; i++) cyc("R3", 1, 32'hAA00 + i, 0, 3'd4, 0, '0);
    rd_reg("R3", 3'd4); check("R3", last_rd, 32'd0);
    rd_reg("R3", 3'd1); check("R3", last_rd, 32'h0000_C000);

    // thresholds 4/4, enable
    cyc("R7", 0, '0, 0, 3'd2, 1, 32'h0004_0004);
    rd_reg("R7", 3'd2); check("R7", last_rd, 32'h0004_0004);
    cyc("R12", 0, '0, 0, 3'd0, 1, 32'h0000_0020);
    rd_reg("R12", 3'd0); check("R12", last_rd, 32'h0000_0020);

    // fill with threshold boundary checks
    for (int i = 0; i < DEPTH; i++) begin
      cyc("R2", 1, 32'hC0DE_0000 + i, 0, 3'd1, 0, '0);
      if (i == 3) begin rd_reg("R7", 3'd1); check("R7", last_rd, 32'h0000_D000); end
      if (i == 4) begin rd_reg("R7", 3'd1); check("R7", last_rd, 32'h0000_F000); end
      if (i == 10) begin rd_reg("R7", 3'd1); check("R7", last_rd, 32'h0000_F000); end
      if (i == 11) begin rd_reg("R7", 3'd1); check("R7", last_rd, 32'h0000_B000); end
    end
    rd_reg("R8", 3'd1); check("R8", last_rd, 32'h0000_3000);
    rd_reg("R8", 3'd4); check("R8", last_rd, 32'd16);

    // R4: overrun
    cyc("R4", 1, 32'hDEAD_BEEF, 0, 3'd4, 0, '0);
    rd_reg("R4", 3'd1); check("R4", last_rd, 32'h0080_3000);
    rd_reg("R4", 3'd4); check("R4", last_rd, 32'd16);

    // R6: write 0 keeps, write 1 clears
    cyc("R6", 0, '0, 0, 3'd1, 1, 32'h0000_0000);
    rd_reg("R6", 3'd1); check("R6", last_rd, 32'h0080_3000);
    cyc("R6", 0, '0, 0, 3'd1, 1, 32'h0080_0000);
    rd_reg("R6", 3'd1); check("R6", last_rd, 32'h0000_3000);

    // R2: simultaneous push and pop at full accepted
    cyc("R2", 1, 32'h1234_5678, 1, 3'd1, 0, '0);
    rd_reg("R2", 3'd1); check("R2", last_rd, 32'h0000_3000);

    // drain in order
    for (int i = 0; i < DEPTH; i++) cyc("R2", 0, '0, 1, 3'd4, 0, '0);

    // R5: underrun
    cyc("R5", 0, '0, 1, 3'd1, 0, '0);
    check("R5", dma_data, 32'h0);
    rd_reg("R5", 3'd1); check("R5", last_rd, 32'h0040_C000);

    // R6: event in same cycle as clear keeps bit set
    cyc("R6", 0, '0, 1, 3'd1, 1, 32'h0040_0000);
    rd_reg("R6", 3'd1); check("R6", last_rd, 32'h0040_C000);

    // R10: flush keeps thresholds and errors
    for (int i = 0; i < 5; i++) cyc("R2", 1, 32'hF0 + i, 0, 3'd4, 0, '0);
    cyc("R10", 1, 32'h77, 1, 3'd0, 1, 32'h0000_0024);
    rd_reg("R10", 3'd4); check("R10", last_rd, 32'd0);
    rd_reg("R10", 3'd1); check("R10", last_rd, 32'h0040_C000);
    rd_reg("R10", 3'd2); check("R10", last_rd, 32'h0004_0004);
    rd_reg("R10", 3'd0); check("R10", last_rd, 32'h0000_0020);

    // R11: block reset and settling window
    cyc("R11", 0, '0, 0, 3'd0, 1, 32'h0000_0001);
    rd_reg("R11", 3'd0); check("R11", last_rd, 32'd0);
    rd_reg("R11", 3'd2); check("R11", last_rd, 32'd0);
    cyc("R11", 0, '0, 0, 3'd0, 1, 32'h0000_0020);
    for (int i = 0; i < SETTLE - 4; i++) cyc("R11", 1, 32'h5500 + i, 1, 3'd4, 0, '0);
    rd_reg("R11", 3'd1); check("R11", last_rd, 32'h0000_C000);
    cyc("R11", 1, 32'h6600, 0, 3'd4, 0, '0);
    cyc("R11", 1, 32'h6601, 0, 3'd4, 0, '0);
    check("R11", last_rd, 32'd1);

    // constrained random traffic
    for (int c = 0; c < 3000; c++) begin
      bit fillp;
      fillp = ((c / 150) % 2) == 0;
      lv = fillp ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
      rd = fillp ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
      a  = 3'($urandom % 6);
      wr = ($urandom % 16 == 0);
      wd = $urandom;
      if (wr && a == 3'd0) begin
        wd = '0;
        wd[5] = ($urandom % 5 != 0);
        wd[2] = ($urandom % 6 == 0);
        wd[0] = ($urandom % 12 == 0);
      end else if (wr && a == 3'd2) begin
        wd = {8'h0, 8'($urandom % 20), 16'($urandom % 20)};
      end
      cyc(tag_of(a), lv, $urandom, rd, a, wr, wd);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule